// File: doc/BRIEF.md
# Bus Parity Launch Unit

This block produces the parity bit for a 32-bit multiplexed address/data bus with a 4-bit command/byte-enable lane. The interface may act as the initiator or as the target of a transfer. On each clock the block XORs the address/data and command/byte-enable lines together. When a phase that this interface owns reaches its qualifying event, the block captures that even-parity bit. One clock later it presents the bit on `par`, with `par_oe` asserted to enable the pad driver.

Ownership follows the role and the direction. As initiator, the interface drives parity for address phases and for write data phases. As target, it drives parity only for read data phases. The qualifying event for an address phase is the address clock itself. For a write data phase it is a clock where the initiator-ready strobe is sampled low. For a read data phase it is a clock where the target-ready strobe is sampled low. Between events the bit is held. The enable stays on while the owned phase continues, so it covers the clock after the phase completes, and it drops once ownership ends. Checking of received parity, error reporting and the tri-state pad sit outside this block.

Top module: `pci_par_gen`

## Requirements
- R1: When `par_oe` is 1 after a launch, the 37 bits formed by `par`, `ad` and `cbe_n` as sampled on the launching clock hold an even number of ones. This means `par` equals the XOR of those 36 bus bits.
- R2: When `is_master`=1 and `addr_phase`=1 on a clock, the next clock shows `par_oe`=1 and the parity of that clock's `ad`/`cbe_n`.
- R3: In an initiator write data phase (`is_master`=1, `data_phase`=1, `is_write`=1), a clock with `irdy_n`=0 launches that clock's parity on the next clock. A clock with `irdy_n`=1 launches nothing.
- R4: In a target read data phase (`is_master`=0, `data_phase`=1, `is_write`=0), a clock with `trdy_n`=0 launches that clock's parity on the next clock. `irdy_n` has no influence on this launch.
- R5: On any clock with no launch, `par` keeps its value on the following clock, whatever `ad` and `cbe_n` carry.
- R6: Once asserted, `par_oe` stays 1 while an owned phase is in progress. It falls on the clock after the first clock on which no owned phase is in progress and no launch occurs.
- R7: `par_oe` stays 0 from an idle state in three cases: initiator read data phases, target address phases and target write data phases.
- R8: Reset is synchronous and active low. The clock after `rst_n`=0 is sampled shows `par`=0 and `par_oe`=0.
- R9: In a target read data phase, `par_oe` rises only on the clock after the first clock with `trdy_n`=0. Earlier wait clocks leave it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad | input | 32 | Address/data bus as seen this clock |
| cbe_n | input | 4 | Command/byte-enable lines as seen this clock |
| addr_phase | input | 1 | Current clock is an address phase |
| data_phase | input | 1 | Current clock belongs to a data phase |
| is_write | input | 1 | Transfer direction: 1 write, 0 read |
| is_master | input | 1 | Role: 1 initiator, 0 target |
| irdy_n | input | 1 | Initiator-ready sample, active low |
| trdy_n | input | 1 | Target-ready sample, active low |
| par | output | 1 | Even-parity bit, one clock after its data |
| par_oe | output | 1 | Drive enable for the parity pad |

## Verification
The bench covers write data phases with initiator wait clocks. A design that launched on every data clock would put parity of non-valid bus contents on `par` at those clocks. It also covers target reads whose ready strobe arrives late. A design that enabled the driver on phase entry would assert `par_oe` before the first valid read data. Phases owned by the other side check that an ownership decode with a swapped role or direction would drive the pad against the other agent. Finally, the clock after completion and the idle clock after it expose a release that comes one clock early or one clock late. The all-ones and single-bit bus patterns catch a parity tree that drops a lane or inverts the sense.

// File: rtl/pci_par_pkg.sv
// Package: shared types and sizes for the bus parity launch unit.
// Assumes one bus clock domain and no knowledge of address decoding.
package pci_par_pkg;

    // Default lane widths of the multiplexed bus.
    localparam int unsigned AD_W_DEF  = 32;
    localparam int unsigned CBE_W_DEF = 4;

    // Phase and role indications presented each clock.
    typedef struct packed {
        logic addr;    // address clock
        logic data;    // data phase clock
        logic write;   // 1 write, 0 read
        logic master;  // 1 initiator, 0 target
    } phase_t;

endpackage

// File: rtl/pci_par_tree.sv
// Module: balanced XOR reduction of WIDTH bits, padded to a power of two.
// Assumes WIDTH >= 1; purely combinational, log2(WIDTH) gate levels deep.
module pci_par_tree #(
    parameter int unsigned WIDTH = 36
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic             odd_out
);
    localparam int unsigned LVL   = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int unsigned LEAVES = 1 << LVL;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    // Leaf layer: real bits, zero padding beyond WIDTH.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < WIDTH) begin : g_real
            assign node[LEAVES-1+i] = bits_in[i];
        end else begin : g_pad
            assign node[LEAVES-1+i] = 1'b0;
        end
    end

    // Internal layers: each node combines its two children.
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_inner
        assign node[k] = node[2*k+1] ^ node[2*k+2];
    end

    assign odd_out = node[0];

endmodule

// File: rtl/pci_par_owner.sv
// Module: decides whether this interface owns the parity line this clock
// and whether the clock is a launching event.
// Assumes the phase flags and ready strobes are already synchronous samples.
module pci_par_owner
    import pci_par_pkg::*;
(
    input  phase_t ph,
    input  logic   irdy_n,
    input  logic   trdy_n,
    output logic   own,
    output logic   launch
);
    logic m_addr, m_wr, s_rd;

    // Classify the clock into the three owned phase kinds.
    always_comb begin
        m_addr = ph.master & ph.addr;
        m_wr   = ph.master & ph.data & ph.write;
        s_rd   = ~ph.master & ph.data & ~ph.write;
    end

    // Ownership spans the whole phase; launch needs the matching strobe.
    always_comb begin
        own    = m_addr | m_wr | s_rd;
        launch = m_addr | (m_wr & ~irdy_n) | (s_rd & ~trdy_n);
    end

endmodule

// File: rtl/pci_par_launch.sv
// Module: single pipeline register holding the parity bit and its enable.
// Assumes synchronous active-low reset; parity input is combinational.
module pci_par_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic odd_in,
    input  logic launch,
    input  logic own,
    output logic par_q,
    output logic oe_q
);
    // Capture on a launch, hold otherwise; enable lives while owned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            if (launch) begin
                par_q <= odd_in;
            end
            oe_q <= launch | (oe_q & own);
        end
    end

endmodule

// File: rtl/pci_par_gen.sv
// Module: top of the bus parity launch unit.
// Computes even parity over address/data and command/byte-enable lanes,
// launches it one clock after an owned qualifying event and drives the
// pad enable while the phase is owned. Assumes the pad sits outside.
module pci_par_gen
    import pci_par_pkg::*;
#(
    parameter int unsigned AD_W  = AD_W_DEF,
    parameter int unsigned CBE_W = CBE_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    input  logic             addr_phase,
    input  logic             data_phase,
    input  logic             is_write,
    input  logic             is_master,
    input  logic             irdy_n,
    input  logic             trdy_n,
    output logic             par,
    output logic             par_oe
);
    localparam int unsigned BUS_W = AD_W + CBE_W;

    phase_t ph;
    logic   odd;
    logic   own;
    logic   launch;

    // Gather the phase flags into one structure.
    always_comb begin
        ph.addr   = addr_phase;
        ph.data   = data_phase;
        ph.write  = is_write;
        ph.master = is_master;
    end

    pci_par_tree #(.WIDTH(BUS_W)) u_tree (
        .bits_in ({cbe_n, ad}),
        .odd_out (odd)
    );

    pci_par_owner u_owner (
        .ph     (ph),
        .irdy_n (irdy_n),
        .trdy_n (trdy_n),
        .own    (own),
        .launch (launch)
    );

    pci_par_launch u_launch (
        .clk    (clk),
        .rst_n  (rst_n),
        .odd_in (odd),
        .launch (launch),
        .own    (own),
        .par_q  (par),
        .oe_q   (par_oe)
    );

endmodule

// File: rtl/pci_par_gen_chk.sv
// Module: checker for pci_par_gen, attached by bind; observes ports only.
module pci_par_gen_chk #(
    parameter int unsigned AD_W  = 32,
    parameter int unsigned CBE_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AD_W-1:0]  ad,
    input logic [CBE_W-1:0] cbe_n,
    input logic             addr_phase,
    input logic             data_phase,
    input logic             is_write,
    input logic             is_master,
    input logic             irdy_n,
    input logic             trdy_n,
    input logic             par,
    input logic             par_oe
);
    logic ev_addr, ev_wr, ev_rd, ev_any, in_owned, m_read, s_other;

    // Independent view of events from the port-level phase rules.
    always_comb begin
        ev_addr  = is_master && addr_phase;
        ev_wr    = is_master && data_phase && is_write && !irdy_n;
        ev_rd    = !is_master && data_phase && !is_write && !trdy_n;
        ev_any   = ev_addr || ev_wr || ev_rd;
        in_owned = ev_addr || (is_master && data_phase && is_write)
                   || (!is_master && data_phase && !is_write);
        m_read   = is_master && data_phase && !is_write && !addr_phase;
        s_other  = !is_master && (addr_phase || (data_phase && is_write));
    end

    // R1 R2: address launch gives even parity one clock later
    a_r2_addr_launch: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr |=> (par_oe && (par == ^$past({cbe_n, ad}))));

    // R1 R3: write launch after initiator ready
    a_r3_write_launch: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr |=> (par_oe && (par == ^$past({cbe_n, ad}))));

    // R1 R4: read launch after target ready
    a_r4_read_launch: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rd |=> (par_oe && (par == ^$past({cbe_n, ad}))));

    // R5: no launch keeps the bit
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_any |=> $stable(par));

    // R6: release once ownership ends
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_owned && !ev_any) |=> !par_oe);

    // R6: enable persists while owned
    a_r6_persist: assert property (@(posedge clk) disable iff (!rst_n)
        (par_oe && in_owned) |=> par_oe);

    // R7: other side's phases start no drive
    a_r7_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_oe && (m_read || s_other)) |=> !par_oe);

    // R9: target read wait clocks before ready keep the pad off
    a_r9_late_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_oe && !is_master && data_phase && !is_write && trdy_n) |=> !par_oe);

    // R8: synchronous reset clears both outputs
    a_r8_reset: assert property (@(posedge clk)
        !rst_n |=> (!par_oe && !par));

endmodule

bind pci_par_gen pci_par_gen_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad         (ad),
    .cbe_n      (cbe_n),
    .addr_phase (addr_phase),
    .data_phase (data_phase),
    .is_write   (is_write),
    .is_master  (is_master),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .par        (par),
    .par_oe     (par_oe)
);

// File: tb/tb_pci_par_gen.sv
`timescale 1ns/1ps
module tb_pci_par_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ad;
    logic [3:0]  cbe_n;
    logic        addr_phase, data_phase, is_write, is_master, irdy_n, trdy_n;
    logic        par, par_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    pci_par_gen dut (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n),
        .addr_phase(addr_phase), .data_phase(data_phase),
        .is_write(is_write), .is_master(is_master),
        .irdy_n(irdy_n), .trdy_n(trdy_n),
        .par(par), .par_oe(par_oe)
    );

    // Vector: a d w m irdy_n trdy_n | ad[32] | cbe_n[4] | exp_oe exp_par | req[4]
    localparam int NV = 17;
    localparam logic [47:0] VECS [0:NV-1] = '{
        {6'b000111, 32'h0000_0000, 4'hF, 2'b00, 4'd6}, // R6 idle
        {6'b101111, 32'h0000_0003, 4'h7, 2'b11, 4'd2}, // R2 write addr, 5 ones
        {6'b011111, 32'hFFFF_FFFF, 4'h0, 2'b11, 4'd5}, // R5 initiator wait
        {6'b011101, 32'h0000_00FF, 4'h0, 2'b10, 4'd3}, // R3 irdy low, 8 ones
        {6'b011100, 32'h0000_0007, 4'h0, 2'b11, 4'd3}, // R3 completion, 3 ones
        {6'b000111, 32'h0000_0000, 4'h0, 2'b01, 4'd6}, // R6 release, hold
        {6'b100111, 32'h0000_0001, 4'h6, 2'b11, 4'd2}, // R2 read addr, 3 ones
        {6'b010100, 32'h0000_0003, 4'h0, 2'b01, 4'd7}, // R7 initiator read data
        {6'b100011, 32'h0000_000F, 4'h0, 2'b01, 4'd7}, // R7 target addr
        {6'b010001, 32'h0000_0000, 4'h0, 2'b01, 4'd9}, // R9 target wait
        {6'b010010, 32'h0000_0003, 4'h0, 2'b10, 4'd4}, // R4 trdy low, irdy high
        {6'b010000, 32'h0000_0001, 4'h0, 2'b11, 4'd4}, // R4 both low
        {6'b010011, 32'h0000_FFFF, 4'hF, 2'b11, 4'd6}, // R6 still owned
        {6'b011000, 32'h0000_0001, 4'h0, 2'b01, 4'd7}, // R7 target write
        {6'b101111, 32'h8000_0000, 4'hE, 2'b10, 4'd1}, // R1 4 ones
        {6'b000111, 32'h0000_0000, 4'h0, 2'b00, 4'd6}, // R6 idle
        {6'b101111, 32'hFFFF_FFFF, 4'h7, 2'b11, 4'd1}  // R1 35 ones
    };

    task automatic check(input logic got_oe, input logic got_par,
                         input logic exp_oe, input logic exp_par, input string req);
        n_chk++;
        if (got_oe !== exp_oe || got_par !== exp_par) begin
            n_fail++;
            $display("FAIL %s: oe/par got %b/%b expected %b/%b",
                     req, got_oe, got_par, exp_oe, exp_par);
        end
    endtask

    task automatic drive(input logic [47:0] v);
        addr_phase = v[47]; data_phase = v[46]; is_write = v[45];
        is_master  = v[44]; irdy_n     = v[43]; trdy_n   = v[42];
        ad = v[41:10]; cbe_n = v[9:6];
    endtask

    initial begin : watchdog
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] lfsr;
        logic        exp_par;
        rst_n = 1'b0;
        drive({6'b101111, 32'hFFFF_FFFF, 4'h7, 6'b0});
        @(negedge clk);
        @(negedge clk);
        check(par_oe, par, 1'b0, 1'b0, "R8 reset state");
        rst_n = 1'b1;

        // Table walk: apply at negedge, result after the next edge.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check(par_oe, par, VECS[i][5], VECS[i][4],
                  $sformatf("R%0d vector %0d", VECS[i][3:0], i));
        end

        // R8: reset in the middle of an owned phase.
        drive({6'b101111, 32'h0000_0001, 4'h0, 6'b0});
        @(negedge clk);
        check(par_oe, par, 1'b1, 1'b1, "R2 before reset");
        rst_n = 1'b0;
        @(negedge clk);
        check(par_oe, par, 1'b0, 1'b0, "R8 mid-phase reset");
        rst_n = 1'b1;

        // R1 R3 R5: pseudo-random write burst with a wait every fourth clock.
        lfsr = 32'hACE1_2345;
        drive({6'b101111, lfsr, 4'h3, 6'b0});
        exp_par = ^{4'h3, lfsr};
        @(negedge clk);
        check(par_oe, par, 1'b1, exp_par, "R2 burst address");
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive({6'b011100, lfsr, lfsr[7:4], 6'b0});
            if ((k % 4) == 3) irdy_n = 1'b1;
            else exp_par = ^{lfsr[7:4], lfsr};
            @(negedge clk);
            check(par_oe, par, 1'b1, exp_par,
                  (k % 4) == 3 ? "R5 wait hold" : "R1 R3 random write");
        end
        drive({6'b000111, 32'h0, 4'h0, 6'b0});
        @(negedge clk);
        check(par_oe, par, 1'b0, exp_par, "R6 burst end");

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule